// File: doc/BRIEF.md
# Windowed Host/Bus Address Translator

This block converts addresses between a host memory space and a peripheral bus address space. It uses a small table of programmable windows. Each window pairs a host base with a bus base and gives both the same size. The forward path maps a host address onto the bus side. The reverse path maps a bus address back onto the host side. The two paths are independent, each takes one registered cycle, and both may be used in the same cycle.

Configuration logic writes window entries through an indexed write port and sets how many leading entries are live. A separate calculator takes the total installed memory size and produces the inbound aperture. The aperture size is that total rounded up to a power of two. The aperture is placed either at offset zero or at an offset equal to its own size. Placing it at zero keeps it below the 4 GiB line for devices that can only drive 32-bit addresses.

Top module: `addr_xlate_top`

## Requirements
- R1: After a synchronous reset, both output valids are low and the live window count is zero.
- R2: With a live window count of zero, each path returns its input address unchanged and `fwd_err_o` is low.
- R3: A forward lookup whose address falls in a live window returns addr − host_base + bus_base with `fwd_err_o` low.
- R4: A reverse lookup whose address falls in a live window returns addr − bus_base + host_base.
- R5: A window covers base ≤ addr < base + size: the base and the last byte hit, and base + size does not.
- R6: When live windows overlap, the entry with the lowest index wins.
- R7: A forward lookup that misses every live window returns all ones (36'hF_FFFF_FFFF by default) and raises `fwd_err_o`.
- R8: A reverse lookup that misses every live window returns its input address unchanged.
- R9: Entries at an index equal to or above the live count never match.
- R10: A lookup issued in the same cycle as a table write uses the table contents from before the write.
- R11: Each output valid follows its input valid one cycle later, and the two paths run in the same cycle without interfering.
- R12: `ap_size` is `mem_total` rounded up to a power of two, one cycle after it is presented; a total of zero gives zero.
- R13: `ap_off` is zero when `mem_total` ≤ 0xC000_0000 and `ap_size` ≤ 2^32; otherwise it equals `ap_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one window entry |
| cfg_idx | input | 3 | Index of the entry written |
| cfg_host | input | 36 | Host-side base of the entry |
| cfg_bus | input | 36 | Bus-side base of the entry |
| cfg_size | input | 36 | Size of the entry in bytes |
| cfg_cnt_we | input | 1 | Load the live window count |
| cfg_cnt | input | 4 | Number of live leading entries |
| fwd_vld_i | input | 1 | Forward request valid |
| fwd_addr_i | input | 36 | Host address to translate |
| fwd_vld_o | output | 1 | Forward result valid |
| fwd_addr_o | output | 36 | Bus address, or all ones on a miss |
| fwd_err_o | output | 1 | Forward miss flag |
| rev_vld_i | input | 1 | Reverse request valid |
| rev_addr_i | input | 36 | Bus address to translate |
| rev_vld_o | output | 1 | Reverse result valid |
| rev_addr_o | output | 36 | Host address |
| mem_total | input | 40 | Total installed memory in bytes |
| ap_size | output | 41 | Power-of-two aperture size |
| ap_off | output | 41 | Aperture placement offset |

## Verification
The bench goes after the window edges. The last byte of a window must hit and the first byte past it must miss. A design with an inclusive upper bound would translate the byte past the window instead of flagging it. The bench also covers the asymmetric miss handling: a design that reused one miss rule for both paths would either pass a bad host address through to the bus or corrupt a reverse address with all ones. Overlapping windows show whether a design lets a later entry override an earlier one. A write in the same cycle as a lookup shows whether the new entry leaks through. The aperture checks sit at 0xC000_0000 and one byte above it, at exact powers of two, and at zero and one. Those are the points where an off-by-one in the rounding or a wrong threshold shows up.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic {DIR_FWD = 1'b0, DIR_REV = 1'b1} xdir_e;
endpackage

// File: rtl/xlate_table.sv
module xlate_table #(
  parameter int NWIN = 8,
  parameter int AW   = 36,
  parameter int IW   = 3,
  parameter int CW   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [IW-1:0]            idx,
  input  logic [AW-1:0]            host_in,
  input  logic [AW-1:0]            bus_in,
  input  logic [AW-1:0]            size_in,
  input  logic                     cnt_we,
  input  logic [CW-1:0]            cnt_in,
  output logic [NWIN-1:0][AW-1:0]  host_base,
  output logic [NWIN-1:0][AW-1:0]  bus_base,
  output logic [NWIN-1:0][AW-1:0]  win_size,
  output logic [CW-1:0]            live_cnt
);
  for (genvar g = 0; g < NWIN; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        host_base[g] <= '0;
        bus_base[g]  <= '0;
        win_size[g]  <= '0;
      end else if (we && idx == IW'(g)) begin
        host_base[g] <= host_in;
        bus_base[g]  <= bus_in;
        win_size[g]  <= size_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         live_cnt <= '0;
    else if (cnt_we) live_cnt <= cnt_in;
  end
endmodule

// File: rtl/xlate_lookup.sv
module xlate_lookup
  import xlate_pkg::*;
#(
  parameter int    NWIN = 8,
  parameter int    AW   = 36,
  parameter int    CW   = 4,
  parameter xdir_e DIR  = DIR_FWD
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CW-1:0]            live_cnt,
  input  logic [NWIN-1:0][AW-1:0]  src_base,
  input  logic [NWIN-1:0][AW-1:0]  dst_base,
  input  logic [NWIN-1:0][AW-1:0]  win_size,
  input  logic                     in_vld,
  input  logic [AW-1:0]            in_addr,
  output logic                     out_vld,
  output logic [AW-1:0]            out_addr,
  output logic                     out_miss
);
  logic          hit;
  logic          miss;
  logic [AW-1:0] res;

  always_comb begin
    hit = 1'b0;
    res = in_addr;
    for (int i = 0; i < NWIN; i++) begin
      if (!hit && (CW'(i) < live_cnt) && (in_addr >= src_base[i]) &&
          ({1'b0, in_addr} < ({1'b0, src_base[i]} + {1'b0, win_size[i]}))) begin
        hit = 1'b1;
        res = in_addr - src_base[i] + dst_base[i];
      end
    end
    miss = !hit && (live_cnt != '0);
    if (miss) res = (DIR == DIR_FWD) ? '1 : in_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_addr <= '0;
      out_miss <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_addr <= res;
        out_miss <= miss;
      end
    end
  end
endmodule

// File: rtl/aperture_calc.sv
module aperture_calc #(
  parameter int MSW = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [MSW-1:0] mem_total,
  output logic [MSW:0]   ap_size,
  output logic [MSW:0]   ap_off
);
  localparam logic [MSW:0] TOT_LIM = (MSW+1)'(64'hC000_0000);
  localparam logic [MSW:0] SZ_LIM  = (MSW+1)'(64'h1_0000_0000);

  logic [MSW-1:0] smear;
  logic [MSW:0]   sz;
  logic [MSW:0]   off;

  always_comb begin
    smear = mem_total - MSW'(1);
    for (int s = 1; s < MSW; s = s * 2) smear = smear | (smear >> s);
    sz  = (mem_total == '0) ? '0 : ({1'b0, smear} + (MSW+1)'(1));
    off = (({1'b0, mem_total} <= TOT_LIM) && (sz <= SZ_LIM)) ? '0 : sz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ap_size <= '0;
      ap_off  <= '0;
    end else begin
      ap_size <= sz;
      ap_off  <= off;
    end
  end
endmodule

// File: rtl/addr_xlate_top.sv
module addr_xlate_top
  import xlate_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 36,
  parameter int MSW  = 40,
  localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int CW  = $clog2(NWIN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [AW-1:0]   cfg_host,
  input  logic [AW-1:0]   cfg_bus,
  input  logic [AW-1:0]   cfg_size,
  input  logic            cfg_cnt_we,
  input  logic [CW-1:0]   cfg_cnt,
  input  logic            fwd_vld_i,
  input  logic [AW-1:0]   fwd_addr_i,
  output logic            fwd_vld_o,
  output logic [AW-1:0]   fwd_addr_o,
  output logic            fwd_err_o,
  input  logic            rev_vld_i,
  input  logic [AW-1:0]   rev_addr_i,
  output logic            rev_vld_o,
  output logic [AW-1:0]   rev_addr_o,
  input  logic [MSW-1:0]  mem_total,
  output logic [MSW:0]    ap_size,
  output logic [MSW:0]    ap_off
);
  logic [NWIN-1:0][AW-1:0] host_base;
  logic [NWIN-1:0][AW-1:0] bus_base;
  logic [NWIN-1:0][AW-1:0] win_size;
  logic [CW-1:0]           win_cnt;
  logic                    rev_miss;

  xlate_table #(.NWIN(NWIN), .AW(AW), .IW(IW), .CW(CW)) u_tab (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
    .host_in(cfg_host), .bus_in(cfg_bus), .size_in(cfg_size),
    .cnt_we(cfg_cnt_we), .cnt_in(cfg_cnt),
    .host_base(host_base), .bus_base(bus_base), .win_size(win_size),
    .live_cnt(win_cnt)
  );

  xlate_lookup #(.NWIN(NWIN), .AW(AW), .CW(CW), .DIR(DIR_FWD)) u_fwd (
    .clk(clk), .rst(rst), .live_cnt(win_cnt),
    .src_base(host_base), .dst_base(bus_base), .win_size(win_size),
    .in_vld(fwd_vld_i), .in_addr(fwd_addr_i),
    .out_vld(fwd_vld_o), .out_addr(fwd_addr_o), .out_miss(fwd_err_o)
  );

  xlate_lookup #(.NWIN(NWIN), .AW(AW), .CW(CW), .DIR(DIR_REV)) u_rev (
    .clk(clk), .rst(rst), .live_cnt(win_cnt),
    .src_base(bus_base), .dst_base(host_base), .win_size(win_size),
    .in_vld(rev_vld_i), .in_addr(rev_addr_i),
    .out_vld(rev_vld_o), .out_addr(rev_addr_o), .out_miss(rev_miss)
  );

  aperture_calc #(.MSW(MSW)) u_ap (
    .clk(clk), .rst(rst), .mem_total(mem_total),
    .ap_size(ap_size), .ap_off(ap_off)
  );
endmodule

// File: rtl/addr_xlate_chk.sv
module addr_xlate_chk #(
  parameter int AW  = 36,
  parameter int MSW = 40,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           fwd_vld_i,
  input logic [AW-1:0]  fwd_addr_i,
  input logic           fwd_vld_o,
  input logic [AW-1:0]  fwd_addr_o,
  input logic           fwd_err_o,
  input logic           rev_vld_i,
  input logic [AW-1:0]  rev_addr_i,
  input logic           rev_vld_o,
  input logic [AW-1:0]  rev_addr_o,
  input logic           rev_miss,
  input logic [CW-1:0]  win_cnt,
  input logic [MSW:0]   ap_size,
  input logic [MSW:0]   ap_off
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!fwd_vld_o && !rev_vld_o && win_cnt == '0));

  a_r2_fwd_identity: assert property (@(posedge clk) disable iff (rst)
    (fwd_vld_i && win_cnt == '0) |=> (fwd_addr_o == $past(fwd_addr_i) && !fwd_err_o));

  a_r2_rev_identity: assert property (@(posedge clk) disable iff (rst)
    (rev_vld_i && win_cnt == '0) |=> (rev_addr_o == $past(rev_addr_i)));

  a_r7_miss_code: assert property (@(posedge clk) disable iff (rst)
    (fwd_vld_o && fwd_err_o) |-> (fwd_addr_o == {AW{1'b1}}));

  a_r8_rev_pass: assert property (@(posedge clk) disable iff (rst)
    rev_vld_i |=> (!rev_miss || rev_addr_o == $past(rev_addr_i)));

  a_r11_fwd_latency: assert property (@(posedge clk) disable iff (rst)
    fwd_vld_i |=> fwd_vld_o);

  a_r11_rev_latency: assert property (@(posedge clk) disable iff (rst)
    !rev_vld_i |=> !rev_vld_o);

  a_r12_pow2: assert property (@(posedge clk) disable iff (rst)
    $countones(ap_size) <= 1);

  a_r13_offset: assert property (@(posedge clk) disable iff (rst)
    (ap_off == '0) || (ap_off == ap_size));
endmodule

bind addr_xlate_top addr_xlate_chk #(.AW(AW), .MSW(MSW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst),
  .fwd_vld_i(fwd_vld_i), .fwd_addr_i(fwd_addr_i),
  .fwd_vld_o(fwd_vld_o), .fwd_addr_o(fwd_addr_o), .fwd_err_o(fwd_err_o),
  .rev_vld_i(rev_vld_i), .rev_addr_i(rev_addr_i),
  .rev_vld_o(rev_vld_o), .rev_addr_o(rev_addr_o), .rev_miss(rev_miss),
  .win_cnt(win_cnt), .ap_size(ap_size), .ap_off(ap_off)
);

// File: tb/tb_addr_xlate_top.sv
module tb_addr_xlate_top;
  localparam int AW = 36;
  localparam int MSW = 40;
  localparam logic [AW-1:0] ONES = '1;
  localparam logic [AW-1:0] GIG = 36'h0_4000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_cnt_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [AW-1:0] cfg_host = '0, cfg_bus = '0, cfg_size = '0;
  logic [3:0] cfg_cnt = '0;
  logic fwd_vld_i = 1'b0, rev_vld_i = 1'b0;
  logic [AW-1:0] fwd_addr_i = '0, rev_addr_i = '0;
  logic fwd_vld_o, fwd_err_o, rev_vld_o;
  logic [AW-1:0] fwd_addr_o, rev_addr_o;
  logic [MSW-1:0] mem_total = '0;
  logic [MSW:0] ap_size, ap_off;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  addr_xlate_top dut (.*);

  // {direction (0 fwd, 1 rev), input, expected, expected forward error}
  localparam int NV = 17;
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 36'h0_6000_0000, 36'h0_A000_0000, 1'b0},
    {1'b0, 36'h0_0000_0000, 36'h0_0000_0000, 1'b0},
    {1'b0, 36'h0_3FFF_FFFF, 36'h0_3FFF_FFFF, 1'b0},
    {1'b0, 36'h1_0000_0000, 36'h0_4000_0000, 1'b0},
    {1'b0, 36'h1_3FFF_FFFF, 36'h0_7FFF_FFFF, 1'b0},
    {1'b0, 36'h1_4000_0000, 36'hF_FFFF_FFFF, 1'b1},
    {1'b0, 36'h3_2345_6780, 36'h0_E345_6780, 1'b0},
    {1'b0, 36'h0_8000_0000, 36'h1_0000_0000, 1'b0},
    {1'b0, 36'hC_0000_0010, 36'h1_4000_0010, 1'b0},
    {1'b0, 36'h0_C000_0000, 36'hF_FFFF_FFFF, 1'b1},
    {1'b0, 36'h2_0000_0000, 36'hF_FFFF_FFFF, 1'b1},
    {1'b1, 36'h0_A000_0000, 36'h0_6000_0000, 1'b0},
    {1'b1, 36'h0_4000_0000, 36'h1_0000_0000, 1'b0},
    {1'b1, 36'h1_7FFF_FFFF, 36'hC_3FFF_FFFF, 1'b0},
    {1'b1, 36'h1_8000_0000, 36'h1_8000_0000, 1'b0},
    {1'b1, 36'h0_C000_0004, 36'h3_0000_0004, 1'b0},
    {1'b1, 36'h1_0000_0000, 36'h0_8000_0000, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_win(input int i, input logic [AW-1:0] h, input logic [AW-1:0] b,
                        input logic [AW-1:0] s);
    cfg_we = 1'b1; cfg_idx = 3'(i); cfg_host = h; cfg_bus = b; cfg_size = s;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_cnt(input int n);
    cfg_cnt_we = 1'b1; cfg_cnt = 4'(n);
    @(negedge clk);
    cfg_cnt_we = 1'b0;
  endtask

  task automatic fwd(input logic [AW-1:0] a);
    fwd_vld_i = 1'b1; fwd_addr_i = a;
    @(negedge clk);
    fwd_vld_i = 1'b0;
  endtask

  task automatic rev(input logic [AW-1:0] a);
    rev_vld_i = 1'b1; rev_addr_i = a;
    @(negedge clk);
    rev_vld_i = 1'b0;
  endtask

  task automatic ap(input logic [MSW-1:0] t, input logic [MSW:0] es, input logic [MSW:0] eo);
    mem_total = t;
    @(negedge clk);
    chk("R12 size", 64'(ap_size), 64'(es));
    chk("R13 offset", 64'(ap_off), 64'(eo));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 fwd valid", 64'(fwd_vld_o), 64'd0);
    chk("R1 rev valid", 64'(rev_vld_o), 64'd0);
    // R2: identity with no live windows, table entry written but count zero
    wr_win(0, 36'h0_6000_0000, 36'h0_0000_1000, GIG);
    fwd_vld_i = 1'b1; fwd_addr_i = 36'h0_6000_0000;
    rev_vld_i = 1'b1; rev_addr_i = 36'h0_0000_1234;
    @(negedge clk);
    fwd_vld_i = 1'b0; rev_vld_i = 1'b0;
    chk("R2 fwd identity", 64'(fwd_addr_o), 64'h6000_0000);
    chk("R2 fwd err", 64'(fwd_err_o), 64'd0);
    chk("R2 rev identity", 64'(rev_addr_o), 64'h1234);
    chk("R11 both valid", 64'({fwd_vld_o, rev_vld_o}), 64'd3);
    @(negedge clk);
    chk("R11 valid drops", 64'({fwd_vld_o, rev_vld_o}), 64'd0);

    // Example table, 1 GiB windows
    wr_win(0, 36'h0_0000_0000, 36'h0_0000_0000, GIG);
    wr_win(1, 36'h1_0000_0000, 36'h0_4000_0000, GIG);
    wr_win(2, 36'h0_4000_0000, 36'h0_8000_0000, GIG);
    wr_win(3, 36'h3_0000_0000, 36'h0_C000_0000, GIG);
    wr_win(4, 36'h0_8000_0000, 36'h1_0000_0000, GIG);
    wr_win(5, 36'hC_0000_0000, 36'h1_4000_0000, GIG);
    wr_cnt(6);

    // R3 R4 R5 R7 R8: vector walk
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][73] == 1'b0) begin
        fwd(VEC[v][72:37]);
        chk(VEC[v][0] ? "R7 fwd miss code" : "R3/R5 fwd hit", 64'(fwd_addr_o), 64'(VEC[v][36:1]));
        chk("R7 fwd err flag", 64'(fwd_err_o), 64'(VEC[v][0]));
      end else begin
        rev(VEC[v][72:37]);
        chk("R4/R8 rev", 64'(rev_addr_o), 64'(VEC[v][36:1]));
      end
    end

    // R11: both paths in the same cycle
    fwd_vld_i = 1'b1; fwd_addr_i = 36'h0_6000_0000;
    rev_vld_i = 1'b1; rev_addr_i = 36'h0_A000_0000;
    @(negedge clk);
    fwd_vld_i = 1'b0; rev_vld_i = 1'b0;
    chk("R11 concurrent fwd", 64'(fwd_addr_o), 64'hA000_0000);
    chk("R11 concurrent rev", 64'(rev_addr_o), 64'h6000_0000);

    // R10: write in the same cycle as a lookup
    cfg_we = 1'b1; cfg_idx = 3'd0; cfg_host = '0; cfg_bus = 36'h2_0000_0000; cfg_size = GIG;
    fwd_vld_i = 1'b1; fwd_addr_i = 36'h0_0000_0100;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R10 old contents", 64'(fwd_addr_o), 64'h0100);
    @(negedge clk);
    fwd_vld_i = 1'b0;
    chk("R10 new contents", 64'(fwd_addr_o), 64'h2_0000_0100);

    // R6: overlap, lowest index wins
    wr_win(0, 36'h0_0000_1000, 36'h0_0001_0000, 36'h1000);
    wr_win(1, 36'h0_0000_0000, 36'h0_0002_0000, 36'h1_0000);
    wr_cnt(2);
    fwd(36'h0_0000_1800);
    chk("R6 first match", 64'(fwd_addr_o), 64'h1_0800);
    fwd(36'h0_0000_2000);
    chk("R6 second window", 64'(fwd_addr_o), 64'h2_2000);
    // R9: entries at or above count ignored
    wr_cnt(1);
    fwd(36'h0_0000_2000);
    chk("R9 fwd ignored entry", 64'(fwd_addr_o), 64'(ONES));
    rev(36'h0_0002_2000);
    chk("R9 rev ignored entry", 64'(rev_addr_o), 64'h2_2000);

    // R12 R13: aperture
    ap(40'h1_8000_0000, 41'h2_0000_0000, 41'h2_0000_0000);
    ap(40'h0_C000_0000, 41'h1_0000_0000, 41'h0);
    ap(40'h0_C000_0001, 41'h1_0000_0000, 41'h1_0000_0000);
    ap(40'h0_4000_0000, 41'h0_4000_0000, 41'h0);
    ap(40'h0_5000_0000, 41'h0_8000_0000, 41'h0);
    ap(40'h0, 41'h0, 41'h0);
    ap(40'h1, 41'h1, 41'h0);

    finish_run();
  end
endmodule